// File: doc/BRIEF.md
# S-100 Temporary Bus Master with Counting Bus Cycles

This block lets a plug-in card borrow the S-100 bus from the permanent master. When its enable input is set, it pulls an active-low request line and waits for the permanent master's hold acknowledge. It then takes the bus in two steps. The first step turns on the address and status drivers and sets the buffer direction toward the bus. The second step, one clock later, turns on the data and control drivers. Giving the bus back runs the same steps in reverse.

While it owns the bus, the block divides its system clock down to a bus PHI clock. It runs back-to-back bus cycles, each three PHI periods long, with a sync pulse, a status-valid strobe and either a read or a write strobe. These strobes let any card on the bus latch the address. The address lines carry a free-running count, and the data-out lines carry the low bits of that count. A push-button hold input freezes the count and sounds a buzzer output. If the acknowledge is withdrawn at any time, every driver enable drops at the next clock edge.

Top module: `tmp_bus_master`

## Requirements
- R1: During reset and directly after it: `tma_req_n` = 1; `xfer_stage1`, `xfer_stage2`, `dir_master`, `bus_phi`, `bus_sync`, `bus_dbin` and `buzzer` = 0; `bus_stval_n` and `bus_wr_n` = 1; `bus_addr` = 0.
- R2: When `run_en` is high and the block is idle, `tma_req_n` goes low at the next edge. No stage enable is set while `hold_ack` is low. `tma_req_n` stays low whenever `xfer_stage1` is high.
- R3: The first edge that sees `hold_ack` high while requesting sets `xfer_stage1` (address/status drivers). `xfer_stage2` (data/control drivers) follows exactly one edge later. `dir_master` is high exactly while `xfer_stage1` is high.
- R4: `bus_phi` runs only while `xfer_stage2` is high. It is high for the first HALF_DIV system clocks of each period and low for the next HALF_DIV. The default HALF_DIV of 25 gives 1 MHz from 50 MHz.
- R5: Each bus cycle spans 6 PHI half-periods, numbered 0 to 5. `bus_sync` is high in halves 0–1. `bus_stval_n` is low in half 3. In halves 2–5 the data strobe is active: `bus_wr_n` goes low if `cyc_write` was 1, or `bus_dbin` goes high if it was 0. `cyc_write` is sampled at each cycle boundary and applies to the following cycle.
- R6: When `run_en` drops while the block runs, it first clears `xfer_stage2` and stops all strobes and PHI. One edge later it clears `xfer_stage1`. One edge after that it raises `tma_req_n`.
- R7: If `hold_ack` is low at an edge while any stage is active, that edge clears both stages, `dir_master`, PHI and all strobes, and raises `tma_req_n`. If `run_en` is still high, a new request follows one edge later.
- R8: The count advances by one at the end of each completed bus cycle and wraps from all ones (0xFFFF at default width) to 0. `bus_addr` shows the count, and `bus_dout` shows its low DATA_W bits. The count is kept across release and regrant.
- R9: `hold_sw` is synchronized through two flops. While the synchronized value is high, `buzzer` is high and the count does not advance; bus cycles keep running. Counting resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Request and keep bus ownership while high |
| hold_sw | input | 1 | Hold push-button, asynchronous, active high |
| cyc_write | input | 1 | 1 selects write cycles, 0 selects read cycles |
| hold_ack | input | 1 | Hold acknowledge from the permanent master |
| tma_req_n | output | 1 | Active-low temporary-master request |
| xfer_stage1 | output | 1 | Enable for address and status drivers |
| xfer_stage2 | output | 1 | Enable for data and control drivers |
| dir_master | output | 1 | Buffer direction, high drives toward the bus |
| bus_phi | output | 1 | Generated bus clock |
| bus_addr | output | ADDR_W | Address lines, carry the count |
| bus_dout | output | DATA_W | Data-out lines, low bits of the count |
| bus_sync | output | 1 | Cycle sync strobe |
| bus_stval_n | output | 1 | Active-low status-valid strobe |
| bus_dbin | output | 1 | Read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| buzzer | output | 1 | Buzzer drive while hold is pressed |

## Verification
The bench targets these failure modes:
- Drivers turned on before the acknowledge arrives, or both stages turned on in the same clock. Either would fight the permanent master's buffers.
- A release that drops the request while a stage is still set.
- An acknowledge withdrawn mid-cycle. A design that only reacts at a cycle boundary would keep driving strobes for several more clocks.
- Hold checked at the wrong point, so the count still steps once after hold is pressed.
- A wrap at the top of the address range that sticks or skips.
- A write/read selection that takes effect mid-cycle instead of at the boundary, which would split one cycle's strobes between both kinds.

// File: rtl/tbm_pkg.sv
// Shared types for the temporary bus master.
// Assumes: nothing beyond the standard language.
package tbm_pkg;

    // Ownership sequence of the handover controller.
    typedef enum logic [2:0] {
        HO_IDLE   = 3'd0,
        HO_REQ    = 3'd1,
        HO_STAGE1 = 3'd2,
        HO_RUN    = 3'd3,
        HO_REL2   = 3'd4,
        HO_REL1   = 3'd5
    } ho_state_t;

    // Bus-cycle strobe group as driven onto the control lines.
    typedef struct packed {
        logic sync;
        logic stval_n;
        logic dbin;
        logic wr_n;
    } strobe_t;

    // Number of PHI half-periods in one bus cycle (3 PHI periods).
    localparam int unsigned HALVES_PER_CYCLE = 6;

    localparam strobe_t STROBE_IDLE = '{sync: 1'b0, stval_n: 1'b1, dbin: 1'b0, wr_n: 1'b1};

endpackage

// File: rtl/tbm_handover.sv
// Handover controller: requests the bus, then enables the driver groups in
// two steps after the acknowledge, and releases them in reverse order.
// A lost acknowledge drops every enable at the next edge.
// Assumes: hold_ack is synchronous to clk.
module tbm_handover
    import tbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic hold_ack,
    output logic tma_req_n,
    output logic stage1,
    output logic stage2,
    output logic running
);

    ho_state_t state, state_nx;

    // Next-state selection for acquisition, run and release.
    always_comb begin
        state_nx = state;
        unique case (state)
            HO_IDLE:   if (run_en) state_nx = HO_REQ;
            HO_REQ:    if (!run_en) state_nx = HO_IDLE;
                       else if (hold_ack) state_nx = HO_STAGE1;
            HO_STAGE1: state_nx = hold_ack ? HO_RUN : HO_IDLE;
            HO_RUN:    if (!hold_ack) state_nx = HO_IDLE;
                       else if (!run_en) state_nx = HO_REL2;
            HO_REL2:   state_nx = hold_ack ? HO_REL1 : HO_IDLE;
            HO_REL1:   state_nx = HO_IDLE;
            default:   state_nx = HO_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HO_IDLE;
        else        state <= state_nx;
    end

    // Output decode of the ownership state.
    always_comb begin
        stage1    = (state == HO_STAGE1) || (state == HO_RUN) || (state == HO_REL2);
        stage2    = (state == HO_RUN);
        running   = (state == HO_RUN);
        tma_req_n = (state == HO_IDLE);
    end

endmodule

// File: rtl/tbm_phi_gen.sv
// PHI generator: divides clk into a bus clock and tracks which half-period
// of the 3-period bus cycle is current. Held at the cycle start when idle.
// Assumes: HALF_DIV >= 1.
module tbm_phi_gen
    import tbm_pkg::*;
#(
    parameter int unsigned HALF_DIV = 25
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    output logic       phi,
    output logic [2:0] half,
    output logic       cyc_end
);

    localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [2:0] HALF_LAST = 3'(HALVES_PER_CYCLE - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             half_end;

    assign half_end = (div_cnt == DIV_LAST);

    // Divider and half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            div_cnt <= '0;
            half    <= '0;
        end else if (half_end) begin
            div_cnt <= '0;
            half    <= (half == HALF_LAST) ? 3'd0 : half + 3'd1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // PHI is high in even halves; cycle ends on the last clock of half 5.
    always_comb begin
        phi     = running && !half[0];
        cyc_end = running && half_end && (half == HALF_LAST);
    end

endmodule

// File: rtl/tbm_cycle_engine.sv
// Cycle engine: decodes bus strobes from the half-period index, keeps the
// address count, latches the cycle kind at each boundary and handles hold.
// Assumes: SYNC_STAGES >= 2, DATA_W <= ADDR_W.
module tbm_cycle_engine
    import tbm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [2:0]        half,
    input  logic              cyc_end,
    input  logic              hold_sw,
    input  logic              cyc_write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output strobe_t           strobes,
    output logic              buzzer
);

    logic [SYNC_STAGES-1:0] hold_pipe;
    logic                   hold_s;
    logic                   wr_mode;
    logic [ADDR_W-1:0]      count;

    assign hold_s = hold_pipe[SYNC_STAGES-1];

    // Hold button synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_pipe <= '0;
        else        hold_pipe <= {hold_pipe[SYNC_STAGES-2:0], hold_sw};
    end

    // Cycle kind: tracks the input while idle, latched at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wr_mode <= 1'b0;
        else if (!running || cyc_end)  wr_mode <= cyc_write;
    end

    // Address count: one step per completed cycle unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (cyc_end && !hold_s) count <= count + 1'b1;
    end

    // Strobe decode from the half-period index.
    always_comb begin
        strobes = STROBE_IDLE;
        if (running) begin
            strobes.sync    = (half < 3'd2);
            strobes.stval_n = (half != 3'd3);
            strobes.dbin    = !wr_mode && (half >= 3'd2);
            strobes.wr_n    = !(wr_mode && (half >= 3'd2));
        end
    end

    // Bus values and buzzer.
    always_comb begin
        addr   = count;
        dout   = count[DATA_W-1:0];
        buzzer = hold_s;
    end

endmodule

// File: rtl/tmp_bus_master.sv
// Temporary bus master top: joins the handover controller, PHI generator
// and cycle engine. Outputs are values and enables; external buffers do the
// actual tristating under xfer_stage1/xfer_stage2.
// Assumes: hold_ack synchronous to clk; DATA_W <= ADDR_W.
module tmp_bus_master
    import tbm_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 25,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              hold_sw,
    input  logic              cyc_write,
    input  logic              hold_ack,
    output logic              tma_req_n,
    output logic              xfer_stage1,
    output logic              xfer_stage2,
    output logic              dir_master,
    output logic              bus_phi,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_sync,
    output logic              bus_stval_n,
    output logic              bus_dbin,
    output logic              bus_wr_n,
    output logic              buzzer
);

    logic       running;
    logic [2:0] half;
    logic       cyc_end;
    strobe_t    strobes;

    tbm_handover u_handover (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .hold_ack  (hold_ack),
        .tma_req_n (tma_req_n),
        .stage1    (xfer_stage1),
        .stage2    (xfer_stage2),
        .running   (running)
    );

    tbm_phi_gen #(.HALF_DIV(HALF_DIV)) u_phi (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .phi     (bus_phi),
        .half    (half),
        .cyc_end (cyc_end)
    );

    tbm_cycle_engine #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .half      (half),
        .cyc_end   (cyc_end),
        .hold_sw   (hold_sw),
        .cyc_write (cyc_write),
        .addr      (bus_addr),
        .dout      (bus_dout),
        .strobes   (strobes),
        .buzzer    (buzzer)
    );

    // Direction follows ownership of the first driver group; strobes out.
    always_comb begin
        dir_master  = xfer_stage1;
        bus_sync    = strobes.sync;
        bus_stval_n = strobes.stval_n;
        bus_dbin    = strobes.dbin;
        bus_wr_n    = strobes.wr_n;
    end

endmodule

// File: rtl/tbm_checker.sv
// Protocol checker for the temporary bus master, bound to every instance.
// Assumes: observes top-level ports only.
module tbm_checker #(
    parameter int unsigned ADDR_W = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic              hold_ack,
    input logic              tma_req_n,
    input logic              xfer_stage1,
    input logic              xfer_stage2,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_sync,
    input logic              bus_stval_n,
    input logic              bus_dbin,
    input logic              bus_wr_n,
    input logic              buzzer
);

    AST_REQ_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stage1 |-> !tma_req_n); // R2

    AST_STAGE2_AFTER_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_stage2) |-> $past(xfer_stage1)); // R3

    AST_STROBES_NEED_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sync || bus_dbin || !bus_wr_n || !bus_stval_n) |-> xfer_stage2); // R5

    AST_ONE_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_dbin && !bus_wr_n)); // R5

    AST_STAGE1_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_stage1) |-> !xfer_stage2); // R6

    AST_GRANT_LOSS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ack && xfer_stage1) |=> (!xfer_stage1 && !xfer_stage2)); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_addr) |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1))); // R8

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |=> $stable(bus_addr)); // R9

endmodule

bind tmp_bus_master tbm_checker #(.ADDR_W(ADDR_W)) i_tbm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_ack    (hold_ack),
    .tma_req_n   (tma_req_n),
    .xfer_stage1 (xfer_stage1),
    .xfer_stage2 (xfer_stage2),
    .bus_addr    (bus_addr),
    .bus_sync    (bus_sync),
    .bus_stval_n (bus_stval_n),
    .bus_dbin    (bus_dbin),
    .bus_wr_n    (bus_wr_n),
    .buzzer      (buzzer)
);

// File: tb/test_tmp_bus_master.sv
// Self-checking bench: vector table for counting/hold/cycle kind, then
// directed tests for reset, acquisition, release, grant loss and wrap.
module test_tmp_bus_master;

    localparam int unsigned HALF_DIV = 2;
    localparam int unsigned ADDR_W   = 10;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned CYC_CLKS = 6 * HALF_DIV;
    localparam int unsigned ADDR_MAX = (1 << ADDR_W) - 1;

    // Entry: {cyc_write, hold, cycles[5:0]}; cycles >= 2.
    localparam logic [7:0] VEC [0:5] = '{
        8'b1_0_000011, 8'b0_0_000010, 8'b0_1_000011,
        8'b1_1_000010, 8'b1_0_000010, 8'b0_0_000100
    };

    logic clk = 1'b0;
    logic rst_n, run_en, hold_sw, cyc_write, hold_ack;
    logic tma_req_n, xfer_stage1, xfer_stage2, dir_master, bus_phi;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dout;
    logic bus_sync, bus_stval_n, bus_dbin, bus_wr_n, buzzer;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    tmp_bus_master #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tmp_bus_master (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold_sw(hold_sw),
        .cyc_write(cyc_write), .hold_ack(hold_ack), .tma_req_n(tma_req_n),
        .xfer_stage1(xfer_stage1), .xfer_stage2(xfer_stage2), .dir_master(dir_master),
        .bus_phi(bus_phi), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_sync(bus_sync),
        .bus_stval_n(bus_stval_n), .bus_dbin(bus_dbin), .bus_wr_n(bus_wr_n), .buzzer(buzzer)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; hold_sw = 1'b0; cyc_write = 1'b1; hold_ack = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 req_n", tma_req_n, 1);
        chk("R1 stages", {xfer_stage1, xfer_stage2, dir_master}, 0);
        chk("R1 strobes", {bus_phi, bus_sync, bus_dbin, buzzer}, 0);
        chk("R1 inactive-high", {bus_stval_n, bus_wr_n}, 3);
        chk("R1 addr", bus_addr, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", {tma_req_n, xfer_stage1}, 2);

        // R2 request without grant
        run_en = 1'b1;
        tick(1);
        chk("R2 req low", tma_req_n, 0);
        tick(3);
        chk("R2 no drive before ack", {xfer_stage1, xfer_stage2, dir_master}, 0);
        // R3 staged acquisition
        hold_ack = 1'b1;
        tick(1);
        chk("R3 stage1 first", {xfer_stage1, xfer_stage2, dir_master}, 3'b101);
        tick(1);
        chk("R3 stage2 next", {xfer_stage1, xfer_stage2}, 2'b11);
        // R4/R5 first cycle, write kind, j=0
        chk("R4 phi high half0", bus_phi, 1);
        chk("R5 sync half0", bus_sync, 1);
        chk("R5 no data strobe half0", {bus_wr_n, bus_dbin}, 2'b10);
        tick(2);
        chk("R4 phi low half1", bus_phi, 0);
        chk("R5 sync half1", bus_sync, 1);
        tick(2);
        chk("R5 sync off half2", bus_sync, 0);
        chk("R5 write strobe half2", {bus_wr_n, bus_dbin, bus_stval_n}, 3'b001);
        tick(2);
        chk("R5 stval half3", bus_stval_n, 0);
        tick(2);
        chk("R5 stval off half4", {bus_stval_n, bus_wr_n}, 2'b10);
        tick(4);
        exp_cnt = 1;
        chk("R8 first increment", bus_addr, exp_cnt);
        chk("R5 boundary strobes", {bus_sync, bus_wr_n}, 2'b11);

        // Vector walk at cycle boundaries
        for (int v = 0; v < 6; v++) begin
            int n;
            n = int'(VEC[v][5:0]);
            cyc_write = VEC[v][7];
            hold_sw   = VEC[v][6];
            tick(CYC_CLKS * (n - 1) + 4);
            if (VEC[v][7]) chk("R5 vec write strobe", {bus_wr_n, bus_dbin}, 2'b00);
            else           chk("R5 vec read strobe", {bus_wr_n, bus_dbin}, 2'b11);
            tick(CYC_CLKS - 4);
            if (!VEC[v][6]) exp_cnt += n;
            chk("R8 vec count", bus_addr, exp_cnt);
            chk("R8 vec dout", bus_dout, exp_cnt & 8'hFF);
            chk("R9 vec buzzer", buzzer, int'(VEC[v][6]));
        end

        // R6 release order
        run_en = 1'b0;
        tick(1);
        chk("R6 stage2 off first", {xfer_stage1, xfer_stage2, tma_req_n}, 3'b100);
        chk("R6 strobes stop", {bus_phi, bus_sync, bus_dbin, bus_wr_n}, 4'b0001);
        tick(1);
        chk("R6 stage1 off", {xfer_stage1, dir_master, tma_req_n}, 3'b000);
        tick(1);
        chk("R6 req released", tma_req_n, 1);
        chk("R8 count kept", bus_addr, exp_cnt);
        hold_ack = 1'b0;

        // R7 grant withdrawn mid-cycle
        run_en = 1'b1;
        tick(3);
        chk("R2 waiting no drive", {tma_req_n, xfer_stage1}, 2'b00);
        hold_ack = 1'b1;
        tick(2);
        chk("R3 regrant running", xfer_stage2, 1);
        tick(5);
        hold_ack = 1'b0;
        tick(1);
        chk("R7 enables dropped", {xfer_stage1, xfer_stage2, dir_master}, 0);
        chk("R7 strobes dropped", {bus_phi, bus_sync, bus_dbin, bus_wr_n, bus_stval_n}, 5'b00011);
        chk("R7 req released", tma_req_n, 1);
        tick(1);
        chk("R7 re-request", tma_req_n, 0);
        chk("R8 partial cycle no step", bus_addr, exp_cnt);

        // R8 wrap
        hold_ack = 1'b1;
        tick(2);
        tick(CYC_CLKS * (ADDR_MAX - exp_cnt));
        chk("R8 top value", bus_addr, ADDR_MAX);
        chk("R8 top dout", bus_dout, 8'hFF);
        tick(CYC_CLKS);
        chk("R8 wrap addr", bus_addr, 0);
        chk("R8 wrap dout", bus_dout, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule